// File: doc/BRIEF.md
# Addressable Bit Latch with Demultiplexer Mode

This block keeps a small array of single-bit entries, eight by default, and drives them onto a parallel output word. A serial data bit and a binary entry address arrive together with two active-low mode controls. The two controls choose one of four modes:

- **Write one entry.** The addressed entry takes the data bit.
- **Hold.** Every entry keeps its value.
- **Decode.** The data bit is steered onto the addressed output line only. This mode does not touch the stored entries.
- **Clear.** Both the entries and the outputs go to zero.

Because decode mode leaves the stored entries alone, one instance can serve two purposes. It can be a bit-addressable control register, and between writes it can be borrowed as a 1-of-N strobe generator.

The model is fully synchronous to one clock. The mode, address and data are sampled on the rising edge, and the output word is a register. A small monitor raises a one-cycle flag whenever the address moves while writes stay enabled on consecutive cycles. Such a move could corrupt an entry in a level-sensitive implementation, so software and integrators should change the address only in hold mode.

Top module: `addr_bit_latch`

## Requirements
- R1: Address value k selects output bit k and stored entry k: address 0 maps to bit 0 and address N-1 to bit N-1. The address is an unsigned binary number, bit 0 least significant.
- R2: With wr_en_n=0 and clr_n=1 (write mode), the addressed entry takes din at the clock edge and every other entry keeps its value. The output word then shows all stored entries including the new one.
- R3: With wr_en_n=1 and clr_n=1 (hold mode), no entry changes whatever din and addr carry, and the output word shows the stored entries.
- R4: With wr_en_n=0 and clr_n=0 (decode mode), the addressed output bit equals din and every other output bit is 0.
- R5: Decode mode leaves the stored entries unchanged, so a later hold cycle shows the values stored before decode mode began.
- R6: With wr_en_n=1 and clr_n=0 (clear mode), all output bits are 0 and all stored entries are cleared, whatever addr and din carry. A following hold cycle shows all zeros.
- R7: addr_violation is 1 for exactly the cycle after an edge at which write mode was sampled, write mode was also sampled at the previous edge, and the two sampled addresses differ. In every other cycle it is 0. The write still takes place.
- R8: A synchronous active-low rst_n clears every stored entry, the output word and addr_violation, regardless of the mode controls.
- R9: Every output reflects the inputs sampled at the preceding rising edge: one register of latency, with no change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of all state |
| wr_en_n | input | 1 | Active-low write/decode enable (mode control) |
| clr_n | input | 1 | Active-low clear (mode control) |
| addr | input | ADDR_W (3) | Entry / output line select |
| din | input | 1 | Serial data bit |
| q | output | NUM_ENTRIES (8) | Registered output word |
| addr_violation | output | 1 | One-cycle flag for an address move during consecutive write cycles |

## Verification
Every result of this block is due one clock edge after the inputs that cause it. This holds for the output word in all four modes and for the violation flag, which compares the current and the previous sampled address. The bench drives inputs on the falling edge and samples on the following falling edge, half a period after the capturing rising edge. One directed check also samples just before that rising edge, to confirm that nothing moves early. Stored-state effects (decode not disturbing, clear erasing) are observed one hold cycle later through the output word.

// File: rtl/addr_bit_latch_pkg.sv
// Package: shared mode type and helpers for the addressable bit latch.
// Assumes: mode controls are active-low and already synchronous to clk.
package addr_bit_latch_pkg;

    // Operating modes selected by the two active-low controls.
    typedef enum logic [1:0] {
        MODE_WRITE  = 2'd0,  // wr_en_n=0, clr_n=1
        MODE_HOLD   = 2'd1,  // wr_en_n=1, clr_n=1
        MODE_DECODE = 2'd2,  // wr_en_n=0, clr_n=0
        MODE_CLEAR  = 2'd3   // wr_en_n=1, clr_n=0
    } latch_mode_e;

endpackage

// File: rtl/latch_mode_decode.sv
// Module: latch_mode_decode
// Purpose: turns the two active-low controls into one mode value.
// Assumes: inputs are sampled by the downstream registers; purely combinational.
module latch_mode_decode
    import addr_bit_latch_pkg::*;
(
    input  logic        wr_en_n,
    input  logic        clr_n,
    output latch_mode_e mode
);

    // Map control pair to the operating mode.
    always_comb begin
        unique case ({wr_en_n, clr_n})
            2'b01:   mode = MODE_WRITE;
            2'b11:   mode = MODE_HOLD;
            2'b00:   mode = MODE_DECODE;
            default: mode = MODE_CLEAR;
        endcase
    end

endmodule

// File: rtl/latch_store_array.sv
// Module: latch_store_array
// Purpose: holds NUM_ENTRIES single-bit entries; writes one entry in write
// mode, clears all in clear mode, holds otherwise.
// Assumes: synchronous active-low reset; next-state vector exported so the
// output stage can register it without an extra cycle.
module latch_store_array
    import addr_bit_latch_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    localparam int ADDR_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  latch_mode_e            mode,
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   din,
    output logic [NUM_ENTRIES-1:0] store_next,
    output logic [NUM_ENTRIES-1:0] store_q
);

    for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_entry
        logic hit;
        // Entry gi is selected when the address equals its index.
        assign hit = (addr == ADDR_W'(gi));

        // Next value of entry gi for the current mode.
        always_comb begin
            unique case (mode)
                MODE_WRITE: store_next[gi] = hit ? din : store_q[gi];
                MODE_CLEAR: store_next[gi] = 1'b0;
                default:    store_next[gi] = store_q[gi];
            endcase
        end

        // Entry storage register.
        always_ff @(posedge clk) begin
            if (!rst_n) store_q[gi] <= 1'b0;
            else        store_q[gi] <= store_next[gi];
        end
    end

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLD) |=> $stable(store_q));

    // R5
    decode_keeps_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DECODE) |=> $stable(store_q));

    // R2
    write_one_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_WRITE) |=> ($countones(store_q ^ $past(store_q)) <= 1));

endmodule

// File: rtl/latch_out_stage.sv
// Module: latch_out_stage
// Purpose: registers the output word: the one-hot decode of din in decode
// mode, otherwise the next stored contents.
// Assumes: store_next already holds zeros in clear mode.
module latch_out_stage
    import addr_bit_latch_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    localparam int ADDR_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  latch_mode_e            mode,
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   din,
    input  logic [NUM_ENTRIES-1:0] store_next,
    output logic [NUM_ENTRIES-1:0] q
);

    logic [NUM_ENTRIES-1:0] demux_word;
    logic [NUM_ENTRIES-1:0] q_next;

    for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_demux
        // Line gi carries din only when it is addressed.
        assign demux_word[gi] = din & (addr == ADDR_W'(gi));
    end

    // Choose between the steered data and the stored word.
    always_comb begin
        q_next = (mode == MODE_DECODE) ? demux_word : store_next;
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_next;
    end

    // R4
    decode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DECODE) |=> $onehot0(q));

    // R6
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CLEAR) |=> (q == '0));

    // R8
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (q == '0));

endmodule

// File: rtl/addr_change_monitor.sv
// Module: addr_change_monitor
// Purpose: flags an address move between two consecutive write-mode cycles.
// Assumes: flag is registered; it is due one edge after the offending sample.
module addr_change_monitor
    import addr_bit_latch_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  latch_mode_e       mode,
    input  logic [ADDR_W-1:0] addr,
    output logic              violation
);

    logic [ADDR_W-1:0] prev_addr;
    logic              prev_write;
    logic              is_write;

    // Current cycle is a write cycle.
    assign is_write = (mode == MODE_WRITE);

    // Remember last sampled address and whether it was a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_addr  <= '0;
            prev_write <= 1'b0;
        end else begin
            prev_addr  <= addr;
            prev_write <= is_write;
        end
    end

    // Raise the flag for one cycle on an address move inside a write run.
    always_ff @(posedge clk) begin
        if (!rst_n) violation <= 1'b0;
        else        violation <= is_write && prev_write && (addr != prev_addr);
    end

    // R7
    viol_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(violation) |-> $past(is_write));

    // R8
    viol_reset_chk: assert property (@(posedge clk)
        !rst_n |=> !violation);

endmodule

// File: rtl/addr_bit_latch.sv
// Module: addr_bit_latch (top)
// Purpose: addressable bit latch with hold, decode and clear modes plus an
// address-move monitor. Outputs are registered (one cycle latency).
// Assumes: all inputs synchronous to clk; rst_n synchronous, active-low.
module addr_bit_latch
    import addr_bit_latch_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    localparam int ADDR_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_n,
    input  logic                   clr_n,
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   din,
    output logic [NUM_ENTRIES-1:0] q,
    output logic                   addr_violation
);

    latch_mode_e            mode;
    logic [NUM_ENTRIES-1:0] store_next;
    logic [NUM_ENTRIES-1:0] store_q;

    latch_mode_decode u_mode (
        .wr_en_n (wr_en_n),
        .clr_n   (clr_n),
        .mode    (mode)
    );

    latch_store_array #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .addr       (addr),
        .din        (din),
        .store_next (store_next),
        .store_q    (store_q)
    );

    latch_out_stage #(.NUM_ENTRIES(NUM_ENTRIES)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .addr       (addr),
        .din        (din),
        .store_next (store_next),
        .q          (q)
    );

    addr_change_monitor #(.ADDR_W(ADDR_W)) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .addr      (addr),
        .violation (addr_violation)
    );

    // R3
    hold_shows_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLD) |=> (q == store_q));

endmodule

// File: tb/tb_addr_bit_latch.sv
module tb_addr_bit_latch;

    localparam int N  = 8;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en_n = 1'b1;
    logic          clr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          din = 1'b0;
    logic [N-1:0]  q;
    logic          addr_violation;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    addr_bit_latch #(.NUM_ENTRIES(N)) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en_n        (wr_en_n),
        .clr_n          (clr_n),
        .addr           (addr),
        .din            (din),
        .q              (q),
        .addr_violation (addr_violation)
    );

    typedef struct packed {
        logic          en_n;
        logic          cl_n;
        logic [AW-1:0] a;
        logic          d;
        logic [N-1:0]  eq;
        logic          ev;
        logic [7:0]    tag;   // requirement number
    } vec_t;

    // Mode codes: {en_n,cl_n} 01 write, 11 hold, 00 decode, 10 clear.
    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 3'd0, 1'b1, 8'h01, 1'b0, 8'd2},  // write e0
        '{1'b1, 1'b1, 3'd0, 1'b0, 8'h01, 1'b0, 8'd3},  // hold
        '{1'b1, 1'b1, 3'd3, 1'b1, 8'h01, 1'b0, 8'd3},  // hold, addr moved
        '{1'b0, 1'b1, 3'd3, 1'b1, 8'h09, 1'b0, 8'd2},  // write e3
        '{1'b0, 1'b1, 3'd3, 1'b0, 8'h01, 1'b0, 8'd2},  // overwrite e3 with 0
        '{1'b0, 1'b1, 3'd5, 1'b1, 8'h21, 1'b1, 8'd7},  // addr moved in write run
        '{1'b1, 1'b1, 3'd7, 1'b1, 8'h21, 1'b0, 8'd3},  // hold
        '{1'b0, 1'b0, 3'd7, 1'b1, 8'h80, 1'b0, 8'd4},  // decode line 7
        '{1'b0, 1'b0, 3'd2, 1'b0, 8'h00, 1'b0, 8'd4},  // decode din=0
        '{1'b0, 1'b0, 3'd2, 1'b1, 8'h04, 1'b0, 8'd4},  // decode line 2
        '{1'b1, 1'b1, 3'd0, 1'b0, 8'h21, 1'b0, 8'd5},  // hold shows old store
        '{1'b0, 1'b1, 3'd7, 1'b1, 8'hA1, 1'b0, 8'd1},  // write e7 (top bit)
        '{1'b1, 1'b1, 3'd7, 1'b0, 8'hA1, 1'b0, 8'd3},  // hold
        '{1'b1, 1'b0, 3'd4, 1'b1, 8'h00, 1'b0, 8'd6},  // clear
        '{1'b1, 1'b1, 3'd4, 1'b1, 8'h00, 1'b0, 8'd6},  // hold after clear
        '{1'b0, 1'b1, 3'd6, 1'b1, 8'h40, 1'b0, 8'd2},  // write e6
        '{1'b1, 1'b1, 3'd6, 1'b0, 8'h40, 1'b0, 8'd3}   // hold
    };

    task automatic check(input string req, input logic [N-1:0] exp_q, input logic exp_v);
        checks++;
        if (q !== exp_q || addr_violation !== exp_v) begin
            failures++;
            $display("FAIL %s: q=%h viol=%b expected q=%h viol=%b",
                     req, q, addr_violation, exp_q, exp_v);
        end
    endtask

    // Drive on the current falling edge, sample on the next one.
    task automatic step(input logic en, input logic cl, input logic [AW-1:0] a,
                        input logic d);
        wr_en_n = en; clr_n = cl; addr = a; din = d;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        // R8: reset state
        repeat (3) @(negedge clk);
        check("R8 reset state", 8'h00, 1'b0);
        rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            step(VECS[i].en_n, VECS[i].cl_n, VECS[i].a, VECS[i].d);
            check($sformatf("R%0d vector %0d", VECS[i].tag, i), VECS[i].eq, VECS[i].ev);
        end

        // R1/R4: walk every address in decode mode
        for (int a = 0; a < N; a++) begin
            step(1'b0, 1'b0, AW'(a), 1'b1);
            check($sformatf("R1 R4 decode line %0d", a), N'(1) << a, 1'b0);
        end
        // R5: decode walk left the store (0x40) intact
        step(1'b1, 1'b1, 3'd0, 1'b1);
        check("R5 store after decode walk", 8'h40, 1'b0);

        // R7: single pulse, then none while address stays
        step(1'b0, 1'b1, 3'd1, 1'b1);
        check("R7 first write no flag", 8'h42, 1'b0);
        step(1'b0, 1'b1, 3'd2, 1'b1);
        check("R7 flag on move", 8'h46, 1'b1);
        step(1'b0, 1'b1, 3'd2, 1'b1);
        check("R7 flag drops", 8'h46, 1'b0);
        step(1'b0, 1'b0, 3'd4, 1'b1);
        check("R7 no flag in decode", 8'h10, 1'b0);

        // R9: write sampled at next rising edge, not before
        wr_en_n = 1'b0; clr_n = 1'b1; addr = 3'd0; din = 1'b1;
        #4;
        check("R9 no change before edge", 8'h10, 1'b0);
        @(negedge clk);
        check("R9 update after edge", 8'h47, 1'b0);

        // R8: rst_n overrides a write and clears the store
        rst_n = 1'b0;
        step(1'b0, 1'b1, 3'd5, 1'b1);
        check("R8 reset during write", 8'h00, 1'b0);
        rst_n = 1'b1;
        step(1'b1, 1'b1, 3'd5, 1'b1);
        check("R8 store cleared", 8'h00, 1'b0);

        // R6: clear ignores address/data, then hold stays zero
        step(1'b0, 1'b1, 3'd3, 1'b1);
        check("R6 setup write", 8'h08, 1'b0);
        step(1'b1, 1'b0, 3'd3, 1'b1);
        check("R6 clear with active data", 8'h00, 1'b0);
        step(1'b1, 1'b1, 3'd3, 1'b0);
        check("R6 hold after clear", 8'h00, 1'b0);

        finish_run();
    end

endmodule